// File: doc/BRIEF.md
# Slow-Clock Real-Time Timer

This peripheral keeps a 32-bit count of time derived from a slow reference clock of 32768 Hz. A single-cycle enable input marks each reference period. A programmable 16-bit prescaler divides these pulses. Each time the prescaler rolls over, the value counter advances by one and an increment event is raised. The counter is also compared against a programmable alarm. Both events are held as sticky status flags, and a level interrupt combines the flags with a per-source enable.

Software uses a small 32-bit register bus that has an address, a write strobe, a read strobe, write data and combinational read data. Writing the control word with its restart bit set clears the counter and reloads the prescaler in that same write cycle. Reading the status word returns the pending flags, clears them and drops the interrupt.

Top module: `stt_top`

## Requirements
- R1: After reset, the control word (offset 0x0) reads 0x00008000, the alarm (offset 0x4) reads 0xFFFFFFFF, the value (offset 0x8) and the status (offset 0xC) read 0, and irq is low.
- R2: Only address bits 3:0 are decoded, so an address of 0x18 reads the value and an address of 0x14 reads the alarm. Any low nibble other than 0x0, 0x4, 0x8 or 0xC reads as zero.
- R3: A write to the control word with bit 18 set clears the value to zero and reloads the prescaler from the written divisor in bits 15:0. This restart takes priority over a tick in the same cycle.
- R4: With divisor d (1 to 65535), the value advances by one on every d-th slow_en pulse after a restart. A divisor of 0 divides by 32768.
- R5: Status bit 0 (alarm) is set when a tick carries the value to alarm+1. While the alarm holds 0xFFFFFFFF, no tick ever sets it.
- R6: irq is high when (status bit 1 and control bit 17) or (status bit 0 and control bit 16) are both set, and low otherwise.
- R7: A read of offset 0xC returns the flags held before the read and leaves both flags clear from the next cycle, so irq drops.
- R8: The alarm accepts and returns any 32-bit value. Writes to the value and status offsets change nothing.
- R9: Each tick sets status bit 1. When a tick arrives in the same cycle as a status read, the read returns the old flags and the new flag stays set.
- R10: The control word reads back exactly as written, restart bit included. The restart acts only in the write cycle. A divisor written without the restart bit takes effect at the next prescaler reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| slow_en | input | 1 | One-cycle pulse per slow reference period |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- slow_en lasts a single system-clock cycle per slow period, or is held high for several cycles to mean consecutive pulses.
- A status read and a tick may coincide.
- The alarm can be rewritten at any time.

The stimulus changes every input on the falling clock edge. It runs the counter with a divisor of 1 wherever the alarm and interrupt are swept, so each pulse gives exactly one tick. The only long run is the one-second default division.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int BUS_W       = 32;
  localparam int CTL_ALM_IE  = 16;
  localparam int CTL_INC_IE  = 17;
  localparam int CTL_RESTART = 18;
  localparam int FLAG_ALM    = 0;
  localparam int FLAG_INC    = 1;
  localparam int FLAG_W      = 2;

  typedef enum logic [3:0] {
    OFS_CTL    = 4'h0,
    OFS_ALARM  = 4'h4,
    OFS_VALUE  = 4'h8,
    OFS_STATUS = 4'hC
  } reg_ofs_e;
endpackage

// File: rtl/stt_prescaler.sv
module stt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ZERO_DIV = {1'b1, {(DIV_W-1){1'b0}}};

  function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] d);
    return (d == '0) ? ZERO_DIV : d;
  endfunction

  logic [DIV_W-1:0] cnt_q;

  assign tick = slow_en && (cnt_q == DIV_W'(1)) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= ZERO_DIV;
    else if (restart)         cnt_q <= reload_of(divisor);
    else if (slow_en) begin
      if (cnt_q == DIV_W'(1)) cnt_q <= reload_of(divisor);
      else                    cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // R4
  presc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q != '0);
  // R4
  presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en && !restart && cnt_q != DIV_W'(1)) |=> cnt_q == $past(cnt_q) - DIV_W'(1));
endmodule

// File: rtl/stt_value.sv
module stt_value #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] value,
  output logic             inc_ev,
  output logic             alarm_ev
);
  function automatic logic alarm_match(input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] alm);
    return (alm != '1) && ((cur + CNT_W'(1)) == (alm + CNT_W'(1)));
  endfunction

  logic [CNT_W-1:0] value_q;

  assign value    = value_q;
  assign inc_ev   = tick;
  assign alarm_ev = tick && alarm_match(value_q, alarm);

  always_ff @(posedge clk) begin
    if (!rst_n)       value_q <= '0;
    else if (restart) value_q <= '0;
    else if (tick)    value_q <= value_q + CNT_W'(1);
  end

  // R3
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> value_q == '0);
  // R4
  value_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> value_q == $past(value_q) + CNT_W'(1));
  // R5
  alarm_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_ev |=> (value_q == $past(alarm) + CNT_W'(1)) && ($past(alarm) != '1));
endmodule

// File: rtl/stt_status.sv
module stt_status
  import stt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_ev,
  input  logic              alarm_ev,
  input  logic              rd_clear,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flags_q, events;

  always_comb begin
    events           = '0;
    events[FLAG_INC] = inc_ev;
    events[FLAG_ALM] = alarm_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (rd_clear ? '0 : flags_q) | events;
  end

  assign flags = flags_q;

  // R9
  inc_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> flags_q[FLAG_INC]);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !inc_ev && !alarm_ev) |=> flags_q == '0);
  // R5
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FLAG_ALM] && !rd_clear) |=> flags_q[FLAG_ALM]);
endmodule

// File: rtl/stt_top.sv
module stt_top
  import stt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [BUS_W-1:0] CTL_RESET = BUS_W'(1) << (DIV_W - 1);

  logic [3:0]        ofs;
  logic [BUS_W-1:0]  ctl_q;
  logic [CNT_W-1:0]  alarm_q, value;
  logic [FLAG_W-1:0] flags;
  logic              restart, tick, inc_ev, alarm_ev, rd_clear;

  assign ofs      = bus_addr[3:0];
  assign restart  = bus_wr && (ofs == OFS_CTL) && bus_wdata[CTL_RESTART];
  assign rd_clear = bus_rd && (ofs == OFS_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      alarm_q <= '1;
    end else if (bus_wr) begin
      if (ofs == OFS_CTL)   ctl_q   <= bus_wdata;
      if (ofs == OFS_ALARM) alarm_q <= CNT_W'(bus_wdata);
    end
  end

  stt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .restart(restart),
    .divisor(restart ? bus_wdata[DIV_W-1:0] : ctl_q[DIV_W-1:0]), .tick(tick)
  );

  stt_value #(.CNT_W(CNT_W)) u_value (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .alarm(alarm_q),
    .value(value), .inc_ev(inc_ev), .alarm_ev(alarm_ev)
  );

  stt_status u_status (
    .clk(clk), .rst_n(rst_n), .inc_ev(inc_ev), .alarm_ev(alarm_ev),
    .rd_clear(rd_clear), .flags(flags)
  );

  always_comb begin
    case (ofs)
      OFS_CTL:    bus_rdata = ctl_q;
      OFS_ALARM:  bus_rdata = BUS_W'(alarm_q);
      OFS_VALUE:  bus_rdata = BUS_W'(value);
      OFS_STATUS: bus_rdata = BUS_W'(flags);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = (flags[FLAG_INC] && ctl_q[CTL_INC_IE]) || (flags[FLAG_ALM] && ctl_q[CTL_ALM_IE]);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));
  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !inc_ev && !alarm_ev) |=> !irq);
  // R8
  value_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ofs == OFS_VALUE && !tick) |=> $stable(value));
endmodule

// File: tb/stt_top_tb.sv
module stt_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  stt_top u_dut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [31:0] RST_BIT = 32'h0004_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, input logic pulse, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; slow_en = pulse;
    #1; d = bus_rdata;
    @(posedge clk); #1; bus_rd = 1'b0; slow_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    if (n > 0) begin
      @(negedge clk); slow_en = 1'b1;
      repeat (n) @(posedge clk);
      #1; slow_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    // R1 reset state
    rdr(8'h00, 0, rd); check("R1 ctl", rd, 32'h0000_8000);
    rdr(8'h04, 0, rd); check("R1 alarm", rd, 32'hFFFF_FFFF);
    rdr(8'h08, 0, rd); check("R1 value", rd, 0);
    rdr(8'h0C, 0, rd); check("R1 status", rd, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R4 divisor sweep
    for (int d = 1; d <= 5; d++) begin
      wr(8'h00, RST_BIT | d);
      for (int k = 1; k <= 12; k++) begin
        pulses(1);
        rdr(8'h08, 0, rd); check("R4 divide", rd, k / d);
      end
    end

    // R4 divisor zero -> 32768
    wr(8'h00, RST_BIT);
    pulses(32767);
    rdr(8'h08, 0, rd); check("R4 div0 before", rd, 0);
    pulses(1);
    rdr(8'h08, 0, rd); check("R4 div0 after", rd, 1);

    // R5 alarm sweep
    for (int a = 0; a <= 4; a++) begin
      wr(8'h04, a);
      wr(8'h00, RST_BIT | 1);
      rdr(8'h0C, 0, rd);
      for (int k = 1; k <= 7; k++) begin
        pulses(1);
        rdr(8'h0C, 0, rd);
        check("R5 alarm flag", rd, (k == a + 1) ? 32'h3 : 32'h2);
      end
    end
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, RST_BIT | 1);
    rdr(8'h0C, 0, rd);
    for (int k = 1; k <= 5; k++) begin
      pulses(1);
      rdr(8'h0C, 0, rd); check("R5 all-ones no alarm", rd, 32'h2);
    end

    // R6 / R7 interrupt gating and clear
    for (int en = 0; en < 4; en++) begin
      wr(8'h04, 0);
      wr(8'h00, RST_BIT | (en << 16) | 1);
      rdr(8'h0C, 0, rd);
      pulses(1);
      check("R6 irq both flags", {31'b0, irq}, (en != 0) ? 1 : 0);
      rdr(8'h0C, 0, rd); check("R7 read returns flags", rd, 32'h3);
      check("R7 irq dropped", {31'b0, irq}, 0);
      rdr(8'h0C, 0, rd); check("R7 flags cleared", rd, 0);
      wr(8'h04, 5);
      pulses(1);
      check("R6 irq inc only", {31'b0, irq}, en[1] ? 1 : 0);
      rdr(8'h0C, 0, rd);
    end

    // R9 read and tick in same cycle
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, RST_BIT | 1);
    rdr(8'h0C, 0, rd);
    rdr(8'h0C, 1, rd); check("R9 old flags returned", rd, 0);
    rdr(8'h0C, 0, rd); check("R9 new flag kept", rd, 32'h2);

    // R8 read-only registers and alarm write
    wr(8'h00, RST_BIT | 1);
    pulses(3);
    rdr(8'h0C, 0, rd);
    wr(8'h08, 32'h55);
    wr(8'h0C, 32'h3);
    rdr(8'h08, 0, rd); check("R8 value write ignored", rd, 3);
    rdr(8'h0C, 0, rd); check("R8 status write ignored", rd, 0);
    wr(8'h04, 32'hA5A5_5A5A);
    rdr(8'h04, 0, rd); check("R8 alarm readback", rd, 32'hA5A5_5A5A);

    // R2 decode
    rdr(8'h18, 0, rd); check("R2 alias value", rd, 3);
    rdr(8'h14, 0, rd); check("R2 alias alarm", rd, 32'hA5A5_5A5A);
    rdr(8'h02, 0, rd); check("R2 unmapped", rd, 0);
    rdr(8'h0D, 0, rd); check("R2 unmapped high", rd, 0);

    // R3 restart wins over a tick in the same cycle
    wr(8'h00, RST_BIT | 1);
    pulses(4);
    @(negedge clk); bus_addr = 8'h00; bus_wdata = RST_BIT | 1; bus_wr = 1'b1; slow_en = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0; slow_en = 1'b0;
    rdr(8'h08, 0, rd); check("R3 restart priority", rd, 0);

    // R10 stored word and one-shot restart
    wr(8'h00, RST_BIT | 3);
    rdr(8'h00, 0, rd); check("R10 ctl readback", rd, 32'h0004_0003);
    pulses(6);
    rdr(8'h08, 0, rd); check("R10 restart one-shot", rd, 2);
    wr(8'h00, RST_BIT | 2);
    pulses(1);
    wr(8'h00, 3);
    pulses(1);
    rdr(8'h08, 0, rd); check("R10 old reload finishes", rd, 1);
    pulses(3);
    rdr(8'h08, 0, rd); check("R10 new divisor used", rd, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule